// File: doc/BRIEF.md
# Oversampling ADC Result Accumulator

This block sits behind a 10-bit successive-approximation converter and turns a run of conversion samples into one 16-bit result word. A start pulse arms a new series, clears the running sum and captures two settings: how many samples the series holds (1, 4, 8, 16, 32 or 64) and how the finished sum is laid out in the result word. Every sample presented with its valid strobe while a series is armed is added to an unsigned 16-bit sum. When the last sample of the series has been added, the formatted sum is written to the result register and a one-cycle done pulse is given.

The layout choices are right-justified, right-justified after a right shift of 1, 2 or 3 bits (so that 4, 16 or 64 samples yield 11, 12 or 13 bits of effective resolution), and left-justified. Left-justification is only meaningful for a single sample. A series that asks for it with a longer run gets the plain right-justified sum, and a configuration-error flag is raised instead.

Top module: `os_accum`

## Requirements
- R1: While and after reset, before any series completes, result_o is 0x0000, done_o is 0 and cfg_err_o is 0.
- R2: The repeat-count select is decoded at start as 0→1, 1→4, 2→8, 3→16, 4→32 and 5→64 samples; the values 6 and 7 mean 1 sample.
- R3: A start pulse clears the sum and the sample count and captures both selects. Changes to the selects during a series have no effect. A sample presented in the same cycle as start is dropped. A start during a series abandons it without a done pulse.
- R4: Only cycles with sample valid high while a series is armed add to the sum, as a 16-bit unsigned value. result_o changes only in the cycle after the final sample of the series is taken. Partial sums never appear, and result_o holds its value at all other times.
- R5: done_o is high for exactly one cycle, the cycle in which result_o first shows the new result.
- R6: The format select is 3 bits wide. If bit 2 is 0, the sum is shifted right by the number in bits 1:0 (0 to 3) and right-justified, and all upper bits are zero. For example, 16 samples of 0x3FF with no shift give 0x3FF0, 64 samples of 0x200 give 0x8000, and 64 samples of 0x3FF with shift 3 give 0x1FF8.
- R7: If format bit 2 is 1 and the count is 1, the sample appears in bits 15:6 and bits 5:0 are zero (0x3FF reads 0xFFC0).
- R8: If format bit 2 is 1 and the count is above 1, the result is the unshifted right-justified sum. cfg_err_o then reads 1 from the cycle after that start until the cycle after the next start; otherwise cfg_err_o is 0.
- R9: Samples presented while no series is armed (before the first start, or after a series completes) are ignored: no done pulse, and result_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms a new series, clears the sum and captures the selects |
| cnt_sel_i | input | 3 | Repeat-count select (R2) |
| fmt_sel_i | input | 3 | Justify and shift select (R6, R7, R8) |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 10 | Unsigned conversion sample |
| result_o | output | 16 | Formatted result register |
| done_o | output | 1 | One-cycle pulse when result_o is written |
| cfg_err_o | output | 1 | Left-justify was requested with a count above 1 |

## Verification
Start and sample acceptance can fall in the same cycle: the start of a new series can coincide with a valid sample, and a start can also land on the cycle that would have delivered the final sample of a running series. The bench drives both coincidences on purpose, together with random start and strobe patterns. A behavioural model gives start priority: it drops the sample, emits no done, and begins a fresh series. The result, done and error outputs are compared against this model on every clock.

// File: rtl/os_accum.sv
module os_accum #(
  parameter int SMP_W    = 10,
  parameter int ACC_W    = 16,
  parameter int MAX_LOG2 = 6,
  parameter int SH_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       cnt_sel_i,
  input  logic [2:0]       fmt_sel_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [ACC_W-1:0] result_o,
  output logic             done_o,
  output logic             cfg_err_o
);
  localparam int CNT_W = MAX_LOG2 + 1;
  localparam int PAD_W = ACC_W - SMP_W;

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q, n_q, n_sel;
  logic [ACC_W-1:0] acc_q;
  logic             lj_q;
  logic [SH_W-1:0]  sh_q;

  always_comb begin
    case (cnt_sel_i)
      3'd1:    n_sel = CNT_W'(4);
      3'd2:    n_sel = CNT_W'(8);
      3'd3:    n_sel = CNT_W'(16);
      3'd4:    n_sel = CNT_W'(32);
      3'd5:    n_sel = CNT_W'(64);
      default: n_sel = CNT_W'(1);
    endcase
  end

  wire              single  = (n_sel == CNT_W'(1));
  wire              take    = armed_q && smp_valid_i && !start_i;
  wire [ACC_W-1:0]  sum_nx  = acc_q + {{PAD_W{1'b0}}, smp_i};
  wire [CNT_W-1:0]  cnt_nx  = cnt_q + CNT_W'(1);
  wire              last    = take && (cnt_nx == n_q);
  wire [ACC_W-1:0]  fmt_val = lj_q ? {sum_nx[SMP_W-1:0], {PAD_W{1'b0}}}
                                   : (sum_nx >> sh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      cnt_q     <= '0;
      n_q       <= CNT_W'(1);
      acc_q     <= '0;
      lj_q      <= 1'b0;
      sh_q      <= '0;
      cfg_err_o <= 1'b0;
      result_o  <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= last;
      if (start_i) begin
        armed_q   <= 1'b1;
        cnt_q     <= '0;
        acc_q     <= '0;
        n_q       <= n_sel;
        lj_q      <= fmt_sel_i[2] && single;
        sh_q      <= fmt_sel_i[2] ? '0 : fmt_sel_i[SH_W-1:0];
        cfg_err_o <= fmt_sel_i[2] && !single;
      end else if (take) begin
        acc_q <= sum_nx;
        cnt_q <= cnt_nx;
        if (last) begin
          armed_q  <= 1'b0;
          result_o <= fmt_val;
        end
      end
    end
  end

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= n_q);

  p_done_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(armed_q));

  p_left_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && lj_q) |-> (result_o[PAD_W-1:0] == '0));

  p_right_top_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !lj_q && n_q == CNT_W'(1)) |-> (result_o[ACC_W-1:SMP_W] == '0));

  p_err_no_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> !lj_q);
endmodule

// File: tb/os_accum_tb.sv
module os_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  cnt_sel_i = '0;
  logic [2:0]  fmt_sel_i = '0;
  logic        smp_valid_i = 1'b0;
  logic [9:0]  smp_i = '0;
  logic [15:0] result_o;
  logic        done_o;
  logic        cfg_err_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  int m_arm, m_cnt, m_n, m_sum, m_lj, m_sh, m_err, m_res, m_done;

  always #5 clk = ~clk;

  os_accum dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_sel_i(cnt_sel_i),
    .fmt_sel_i(fmt_sel_i), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .result_o(result_o), .done_o(done_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int count_of(input int sel);
    case (sel)
      1: return 4;  2: return 8;  3: return 16;
      4: return 32; 5: return 64; default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = 0; m_cnt = 0; m_n = 1; m_sum = 0; m_lj = 0;
      m_sh = 0; m_err = 0; m_res = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (start_i) begin
        m_arm = 1; m_cnt = 0; m_sum = 0;
        m_n   = count_of(int'(cnt_sel_i));
        m_lj  = (fmt_sel_i[2] && m_n == 1) ? 1 : 0;
        m_err = (fmt_sel_i[2] && m_n != 1) ? 1 : 0;
        m_sh  = fmt_sel_i[2] ? 0 : int'(fmt_sel_i[1:0]);
      end else if (m_arm != 0 && smp_valid_i) begin
        m_sum = m_sum + int'(smp_i);
        m_cnt = m_cnt + 1;
        if (m_cnt == m_n) begin
          m_arm  = 0;
          m_done = 1;
          m_res  = (m_lj != 0) ? ((m_sum * 64) % 65536) : (m_sum >> m_sh);
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, "result_o", int'(result_o), m_res);
    check(cur_req, "done_o", int'(done_o), m_done);
    check(cur_req, "cfg_err_o", int'(cfg_err_o), m_err);
  end

  task automatic do_start(input int cs, input int fs, input bit with_smp, input int v);
    @(negedge clk);
    start_i = 1'b1; cnt_sel_i = 3'(cs); fmt_sel_i = 3'(fs);
    smp_valid_i = with_smp; smp_i = 10'(v);
  endtask

  task automatic feed(input int v);
    @(negedge clk);
    start_i = 1'b0; smp_valid_i = 1'b1; smp_i = 10'(v);
  endtask

  task automatic idle(input int k);
    repeat (k) begin
      @(negedge clk);
      start_i = 1'b0; smp_valid_i = 1'b0;
    end
  endtask

  task automatic series(input int cs, input int fs, input int v, input int exp, input string req);
    cur_req = req;
    do_start(cs, fs, 1'b0, 0);
    for (int i = 0; i < count_of(cs); i++) feed(v);
    idle(2);
    check(req, "series result", int'(result_o), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset result", int'(result_o), 0);
    check("R1", "reset done", int'(done_o), 0);
    check("R1", "reset err", int'(cfg_err_o), 0);
    rst_n = 1'b1;
    cur_req = "R9";
    feed(10'h3FF); feed(10'h155); idle(2);
    check("R9", "pre-start samples ignored", int'(result_o), 0);

    series(0, 0, 10'h3FF, 16'h03FF, "R6");
    series(0, 4, 10'h3FF, 16'hFFC0, "R7");
    series(3, 0, 10'h3FF, 16'h3FF0, "R6");
    series(5, 0, 10'h200, 16'h8000, "R6");
    series(4, 0, 10'h3FF, 16'h7FE0, "R2");
    series(1, 1, 10'h3FF, 16'h07FE, "R6");
    series(3, 2, 10'h1FF, 16'h07FC, "R6");
    series(5, 3, 10'h3FF, 16'h1FF8, "R6");
    series(6, 0, 10'h155, 16'h0155, "R2");
    series(7, 4, 10'h001, 16'h0040, "R7");
    check("R8", "no error for single left", int'(cfg_err_o), 0);
    series(1, 4, 10'h100, 16'h0400, "R8");
    check("R8", "error flag", int'(cfg_err_o), 1);

    cur_req = "R4";
    do_start(2, 0, 1'b0, 0);
    for (int i = 1; i <= 8; i++) begin
      feed(i); idle(i % 3);
    end
    idle(2);
    check("R4", "gapped sum 1..8", int'(result_o), 36);

    cur_req = "R3";
    do_start(1, 0, 1'b0, 0);
    feed(10'h010); cnt_sel_i = 3'd5; fmt_sel_i = 3'd3;
    feed(10'h010); feed(10'h010); feed(10'h010); idle(2);
    check("R3", "selects latched at start", int'(result_o), 16'h0040);

    cur_req = "R9";
    feed(10'h3FF); feed(10'h3FF); feed(10'h3FF); idle(2);
    check("R9", "post-done samples ignored", int'(result_o), 16'h0040);

    cur_req = "R3";
    do_start(0, 0, 1'b1, 10'h3FF);
    feed(10'h001); idle(2);
    check("R3", "start drops coincident sample", int'(result_o), 16'h0001);

    do_start(1, 0, 1'b0, 0);
    feed(10'h100); feed(10'h100); feed(10'h100);
    do_start(0, 0, 1'b1, 10'h100);
    feed(10'h00A); idle(2);
    check("R3", "restart on final-sample cycle", int'(result_o), 16'h000A);

    cur_req = "R3/R4/R5/R8";
    for (int s = 0; s < 40; s++) begin
      do_start($urandom_range(7), $urandom_range(7), 1'($urandom_range(1)), $urandom_range(1023));
      for (int c = 0; c < 70; c++) begin
        @(negedge clk);
        start_i     = ($urandom_range(99) == 0);
        smp_valid_i = ($urandom_range(2) != 0);
        smp_i       = 10'($urandom_range(1023));
        if ($urandom_range(9) == 0) cnt_sel_i = 3'($urandom_range(7));
      end
    end
    idle(3);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule